// File: doc/BRIEF.md
# MDIO Management Register Controller

This block gives software one 32-bit command/result register for reaching PHY management registers over a two-wire serial management bus (MDC clock, bidirectional MDIO data). Software writes a single word that holds an opcode, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. The controller then generates a complete Clause 22 frame on MDC/MDIO. It drives the bits that it owns and releases the data line for the bits that the PHY returns.

When the frame ends, the controller sets a ready flag inside the same register. On a read, it also replaces the low half of the register with the 16 bits it sampled from the PHY. In the same cycle it pulses a one-cycle completion event, which the surrounding logic can fold into an interrupt or status bit. Software polls the ready flag or waits for the event, then reads the register back.

MDC is derived from the system clock. Each half period lasts `CLK_DIV` clock cycles, and MDC runs only while a frame is in flight.

Top module: `mdio_mgmt_ctl`

## Requirements
- R1: After reset the register reads 0x1000_0000 (ready set, every other field zero), MDC is low, `mdio_oe` is low and `mgmt_done` is low.
- R2: A register write accepted while ready is set and carrying opcode 2'b01 (write) or 2'b10 (read) in bits 27:26 makes ready (bit 28) read 0 from the next cycle on.
- R3: A write frame drives all 64 bit times on MDIO, most significant first: 32 ones, start 01, opcode 01, PHY address (bits 25:21), register address (bits 20:16), turnaround 10, then the 16 data bits (bits 15:0).
- R4: A read frame drives the first 46 bit times (32 ones, 01, 10, PHY address, register address). It then holds `mdio_oe` low for the two turnaround bits and the 16 data bits.
- R5: On completion the opcode and address fields keep the written values. After a read, bits 15:0 hold the 16 bits sampled from MDIO on the last 16 MDC rising edges, first sampled bit in bit 15. After a write, bits 15:0 keep the write data.
- R6: Ready returns to 1 exactly 128*CLK_DIV clock cycles after the edge that accepted the command, and never earlier.
- R7: `mgmt_done` is high for exactly one cycle, the first cycle in which ready reads 1 again after a frame.
- R8: A register write made while ready is 0 is ignored. The register fields and the frame on the wire stay those of the command in flight.
- R9: Opcode 2'b00 or 2'b11 starts no frame. MDC stays low, ready reads 1 and `mgmt_done` pulses in the cycle after the write, and the written fields are stored.
- R10: During a frame MDC makes exactly 64 rising edges. The first rising edge comes CLK_DIV cycles after the accepting edge, and each half period lasts CLK_DIV cycles.
- R11: Whenever ready is 1, MDC is low and `mdio_oe` is low.
- R12: Bits 31:29 always read 0, and a value written to bit 28 has no effect on the stored ready flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Write strobe for the command/result register |
| cmd_wdata | input | 32 | Word written into the register |
| cmd_rdata | output | 32 | Current register contents (fields, ready flag, data) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Data value driven onto MDIO |
| mdio_oe | output | 1 | Drive enable for MDIO; low releases the line |
| mdio_i | input | 1 | Sampled level of the MDIO line |
| mgmt_done | output | 1 | One-cycle completion event |

## Verification
Two situations are hard to reach from the ports. The first is a second register write that lands while a frame is still on the wire. The second is completion timing at cycle granularity. The bench reaches the first by issuing a conflicting read command a hundred cycles into a write frame, then confirming that both the register and the captured wire bits belong to the first command. For the second, the bench counts clock cycles to the first MDC rise, to the first fall and to ready separately. A PHY model keyed to the MDC rising-edge count returns read data on falling edges, so that sampling on the wrong edge or at the wrong bit offset shows up in the returned value.

// File: rtl/mdio_ctl_pkg.sv
package mdio_ctl_pkg;

    // Frame geometry (bit times on the wire)
    localparam int PRE_BITS    = 32;
    localparam int FRAME_BITS  = 64;
    localparam int HDR_BITS    = 46;   // preamble .. register address
    localparam int DATA_FIRST  = 48;   // first data bit time
    localparam int IDX_W       = $clog2(FRAME_BITS);
    localparam int RDY_POS     = 28;

    typedef enum logic [1:0] {
        OPC_RSV0  = 2'b00,
        OPC_WRITE = 2'b01,
        OPC_READ  = 2'b10,
        OPC_RSV3  = 2'b11
    } mdio_opc_e;

    // Occupies register bits 27:0 in this order
    typedef struct packed {
        mdio_opc_e   opc;
        logic [4:0]  phy;
        logic [4:0]  rgad;
        logic [15:0] data;
    } mdio_cmd_t;

    function automatic mdio_cmd_t unpack_cmd(input logic [27:0] w);
        mdio_cmd_t c;
        c.opc  = mdio_opc_e'(w[27:26]);
        c.phy  = w[25:21];
        c.rgad = w[20:16];
        c.data = w[15:0];
        return c;
    endfunction

    function automatic logic [31:0] pack_reg(input mdio_cmd_t c, input logic rdy);
        return {3'b000, rdy, c};
    endfunction

    function automatic logic is_xfer(input mdio_opc_e o);
        return (o == OPC_WRITE) || (o == OPC_READ);
    endfunction

    function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_cmd_t c);
        logic [1:0]  ta;
        logic [15:0] payload;
        ta      = (c.opc == OPC_READ) ? 2'b11 : 2'b10;
        payload = (c.opc == OPC_READ) ? 16'hFFFF : c.data;
        return {{PRE_BITS{1'b1}}, 2'b01, c.opc, c.phy, c.rgad, ta, payload};
    endfunction

endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int            CW   = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap     = run && (cnt == LAST);
    assign rise_stb = wrap && !mdc;
    assign fall_stb = wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= !mdc;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_ctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  mdio_cmd_t   cmd,
    input  logic        rise_stb,
    input  logic        fall_stb,
    input  logic        mdio_i,
    output logic        active,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        done,
    output logic [15:0] rdata
);
    logic [FRAME_BITS-1:0] sr;
    logic [IDX_W-1:0]      idx;
    logic                  rd;
    logic                  last;

    assign last    = (idx == IDX_W'(FRAME_BITS - 1));
    assign done    = active && fall_stb && last;
    assign mdio_o  = active && sr[FRAME_BITS-1];
    assign mdio_oe = active && (!rd || (idx < IDX_W'(HDR_BITS)));

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            sr     <= '0;
            idx    <= '0;
            rd     <= 1'b0;
            rdata  <= '0;
        end else if (start && !active) begin
            active <= 1'b1;
            sr     <= build_frame(cmd);
            idx    <= '0;
            rd     <= (cmd.opc == OPC_READ);
        end else if (active) begin
            if (rise_stb && rd && (idx >= IDX_W'(DATA_FIRST)))
                rdata <= {rdata[14:0], mdio_i};
            if (fall_stb) begin
                if (last) begin
                    active <= 1'b0;
                end else begin
                    sr  <= {sr[FRAME_BITS-2:0], 1'b1};
                    idx <= idx + IDX_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/mdio_cmd_reg.sv
module mdio_cmd_reg
    import mdio_ctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [27:0] wfields,
    input  logic        frame_done,
    input  logic [15:0] rdata_in,
    output mdio_cmd_t   next_cmd,
    output logic        start,
    output logic [31:0] reg_q,
    output logic        evt
);
    mdio_cmd_t cur;
    logic      rdy;
    logic      accept;

    assign next_cmd = unpack_cmd(wfields);
    assign accept   = we && rdy;
    assign start    = accept && is_xfer(next_cmd.opc);
    assign reg_q    = pack_reg(cur, rdy);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
            rdy <= 1'b1;
            evt <= 1'b0;
        end else begin
            evt <= 1'b0;
            if (accept) begin
                cur <= next_cmd;
                if (is_xfer(next_cmd.opc)) begin
                    rdy <= 1'b0;
                end else begin
                    rdy <= 1'b1;
                    evt <= 1'b1;
                end
            end else if (frame_done) begin
                rdy <= 1'b1;
                evt <= 1'b1;
                if (cur.opc == OPC_READ)
                    cur.data <= rdata_in;
            end
        end
    end
endmodule

// File: rtl/mdio_mgmt_ctl.sv
module mdio_mgmt_ctl
    import mdio_ctl_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_we,
    input  logic [31:0] cmd_wdata,
    output logic [31:0] cmd_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i,
    output logic        mgmt_done
);
    mdio_cmd_t   nxt_cmd;
    logic        start;
    logic        active;
    logic        rise_stb;
    logic        fall_stb;
    logic        frame_done;
    logic [15:0] rdata;
    logic [3:0]  unused_hi_bits;

    assign unused_hi_bits = cmd_wdata[31:28];

    mdio_cmd_reg u_reg (
        .clk        (clk),
        .rst        (rst),
        .we         (cmd_we),
        .wfields    (cmd_wdata[27:0]),
        .frame_done (frame_done),
        .rdata_in   (rdata),
        .next_cmd   (nxt_cmd),
        .start      (start),
        .reg_q      (cmd_rdata),
        .evt        (mgmt_done)
    );

    mdio_clk_gen #(.DIV(CLK_DIV)) u_clk (
        .clk      (clk),
        .rst      (rst),
        .run      (active),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cmd      (nxt_cmd),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .active   (active),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .done     (frame_done),
        .rdata    (rdata)
    );
endmodule

// File: rtl/mdio_mgmt_ctl_chk.sv
module mdio_mgmt_ctl_chk #(
    parameter int CLK_DIV = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        we,
    input logic [1:0]  wopc,
    input logic        rdy,
    input logic [11:0] fields,
    input logic        mdc,
    input logic        mdio_oe,
    input logic        done
);
    localparam int FRAME_CYC = 2 * 64 * CLK_DIV;

    logic inflight;
    int   cyc;
    logic go;

    assign go = we && rdy && ((wopc == 2'b01) || (wopc == 2'b10));

    always_ff @(posedge clk) begin
        if (rst) begin
            inflight <= 1'b0;
            cyc      <= 0;
        end else if (go) begin
            inflight <= 1'b1;
            cyc      <= 0;
        end else if (inflight) begin
            cyc <= cyc + 1;
            if (rdy) inflight <= 1'b0;
        end
    end

    // R6
    frame_len_chk: assert property (@(posedge clk) disable iff (rst)
        (inflight && rdy) |-> (cyc == FRAME_CYC));

    // R2
    ready_clear_chk: assert property (@(posedge clk) disable iff (rst)
        go |=> !rdy);

    // R7
    done_ready_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> rdy);

    // R7
    ready_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy) |-> done);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        rdy |-> (!mdc && !mdio_oe));

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (we && !rdy) |=> $stable(fields));
endmodule

bind mdio_mgmt_ctl mdio_mgmt_ctl_chk #(.CLK_DIV(CLK_DIV)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .we      (cmd_we),
    .wopc    (cmd_wdata[27:26]),
    .rdy     (cmd_rdata[28]),
    .fields  (cmd_rdata[27:16]),
    .mdc     (mdc),
    .mdio_oe (mdio_oe),
    .done    (mgmt_done)
);

// File: tb/mdio_mgmt_ctl_tb.sv
module mdio_mgmt_ctl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int FRAME_CYC  = 2 * 64 * DIV;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_we = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic        mdc, mdio_o, mdio_oe, mgmt_done;
    logic        phy_drv = 1'b1;

    logic [15:0] phy_rd_data = '0;
    logic        phy_rd_en = 1'b0;
    int          rise_cnt = 0, oe_cnt = 0, rise_base = 0, oe_base = 0;
    logic [63:0] wire_log = '0;

    int checks = 0, errors = 0;
    bit timed_out = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_mgmt_ctl #(.CLK_DIV(DIV)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .cmd_we    (cmd_we),
        .cmd_wdata (cmd_wdata),
        .cmd_rdata (cmd_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (phy_drv),
        .mgmt_done (mgmt_done)
    );

    // PHY model: records driven bits on MDC rise, answers reads on MDC fall
    always @(posedge mdc) begin
        rise_cnt <= rise_cnt + 1;
        if (mdio_oe) oe_cnt <= oe_cnt + 1;
        wire_log <= {wire_log[62:0], mdio_oe ? mdio_o : 1'b1};
    end

    always @(negedge mdc) begin
        automatic int k = rise_cnt - rise_base;
        if (phy_rd_en && k >= 48 && k <= 63)
            phy_drv <= phy_rd_data[4'(63 - k)];
        else
            phy_drv <= 1'b1;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_reg(input logic rdy, input logic [1:0] op,
                                            input logic [4:0] phy, input logic [4:0] rg,
                                            input logic [15:0] d);
        return {3'b000, rdy, op, phy, rg, d};
    endfunction

    task automatic issue(input logic [31:0] w);
        @(negedge clk);
        rise_base = rise_cnt;
        oe_base   = oe_cnt;
        cmd_we    = 1'b1;
        cmd_wdata = w;
        @(posedge clk);
        @(negedge clk);
        cmd_we    = 1'b0;
    endtask

    task automatic wait_cond_mdc(input logic lvl, output int n);
        n = 0;
        while (mdc !== lvl && n < 4 * FRAME_CYC) begin
            @(posedge clk); n++; @(negedge clk);
        end
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (cmd_rdata[28] !== 1'b1 && n < 4 * FRAME_CYC) begin
            @(posedge clk); n++; @(negedge clk);
        end
    endtask

    task automatic t_reset;
        chk("R1 register", cmd_rdata, 64'h1000_0000);
        chk("R1 mdc", mdc, 0);
        chk("R1 oe", mdio_oe, 0);
        chk("R1 done", mgmt_done, 0);
    endtask

    task automatic t_write(input logic [3:0] hi, input logic [4:0] phy,
                           input logic [4:0] rg, input logic [15:0] d);
        int n1, n2, n3;
        issue({hi, 2'b01, phy, rg, d});
        chk("R2 ready cleared", cmd_rdata[28], 0);
        wait_cond_mdc(1'b1, n1);
        chk("R10 first rise", n1, DIV);
        wait_cond_mdc(1'b0, n2);
        chk("R10 high half", n2, DIV);
        wait_ready(n3);
        chk("R6 frame length", n1 + n2 + n3, FRAME_CYC);
        chk("R7 done at ready", mgmt_done, 1);
        chk("R3 wire bits", wire_log, {32'hFFFF_FFFF, 2'b01, 2'b01, phy, rg, 2'b10, d});
        chk("R3 driven count", oe_cnt - oe_base, 64);
        chk("R10 rise count", rise_cnt - rise_base, 64);
        chk("R5 R12 write result", cmd_rdata, exp_reg(1'b1, 2'b01, phy, rg, d));
        @(negedge clk);
        chk("R7 single pulse", mgmt_done, 0);
        chk("R11 idle mdc", mdc, 0);
        chk("R11 idle oe", mdio_oe, 0);
    endtask

    task automatic t_read(input logic [4:0] phy, input logic [4:0] rg,
                          input logic [15:0] pdat, input logic [15:0] wdat);
        int n;
        phy_rd_en   = 1'b1;
        phy_rd_data = pdat;
        issue({4'h0, 2'b10, phy, rg, wdat});
        chk("R2 ready cleared", cmd_rdata[28], 0);
        wait_ready(n);
        chk("R6 frame length", n, FRAME_CYC);
        chk("R7 done at ready", mgmt_done, 1);
        chk("R4 header bits", {18'h0, wire_log[63:18]},
            {18'h0, 32'hFFFF_FFFF, 2'b01, 2'b10, phy, rg});
        chk("R4 driven count", oe_cnt - oe_base, 46);
        chk("R5 read result", cmd_rdata, exp_reg(1'b1, 2'b10, phy, rg, pdat));
        @(negedge clk);
        chk("R7 single pulse", mgmt_done, 0);
        phy_rd_en = 1'b0;
    endtask

    task automatic t_busy;
        int n;
        issue({4'h0, 2'b01, 5'h03, 5'h07, 16'hA5A5});
        repeat (100) @(negedge clk);
        cmd_we    = 1'b1;
        cmd_wdata = {4'h0, 2'b10, 5'h1F, 5'h1F, 16'h0000};
        @(posedge clk);
        @(negedge clk);
        cmd_we = 1'b0;
        chk("R8 busy fields", cmd_rdata, exp_reg(1'b0, 2'b01, 5'h03, 5'h07, 16'hA5A5));
        wait_ready(n);
        chk("R8 result kept", cmd_rdata, exp_reg(1'b1, 2'b01, 5'h03, 5'h07, 16'hA5A5));
        chk("R8 wire kept", wire_log, {32'hFFFF_FFFF, 4'b0101, 5'h03, 5'h07, 2'b10, 16'hA5A5});
        chk("R8 one frame", rise_cnt - rise_base, 64);
    endtask

    task automatic t_badop(input logic [1:0] op);
        issue({4'hF, op, 5'h0A, 5'h15, 16'hBEEF});
        chk("R9 ready stays", cmd_rdata[28], 1);
        chk("R9 event", mgmt_done, 1);
        chk("R12 upper bits", cmd_rdata, exp_reg(1'b1, op, 5'h0A, 5'h15, 16'hBEEF));
        @(negedge clk);
        chk("R9 single event", mgmt_done, 0);
        repeat (4 * DIV) @(negedge clk);
        chk("R9 no mdc", rise_cnt - rise_base, 0);
        chk("R9 no drive", mdio_oe, 0);
    endtask

    task automatic run_all;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_write(4'h0, 5'h01, 5'h00, 16'h8000);
        t_write(4'hF, 5'h1F, 5'h1F, 16'h0001);
        t_read(5'h02, 5'h03, 16'hC35A, 16'h1111);
        t_read(5'h1E, 5'h01, 16'h8001, 16'hFFFF);
        t_busy;
        t_badop(2'b00);
        t_badop(2'b11);
        t_read(5'h00, 5'h1F, 16'hFFFF, 16'h0000);
    endtask

    initial begin
        fork
            run_all;
            begin
                #(CLK_PERIOD * 150000);
                timed_out = 1'b1;
            end
        join_any
        if (timed_out) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule